// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

The controller gathers a small set of synchronous interrupt sources and presents one maskable interrupt request line to a processor. Each source has its own 3-bit priority level, where 0 is the most urgent, and its own mask bit. A rising edge on a source input latches a pending bit. The request line is raised while at least one pending source qualifies. When the processor acknowledges, the controller returns the type number of the best qualifying source at that instant. It then moves that source from pending to in-service.

Software sets masks, per-source levels and a global threshold through a small register write/read port. Writing an end-of-interrupt command releases an in-service source. That write may name the source, or it may release whichever in-service source is most urgent. Because in-service sources block requests of lower urgency, handlers nest. A more urgent source can interrupt a running handler. A source of equal or lower urgency waits.

Top module: `nic_ctrl`

## Requirements
- R1: A 0-to-1 transition on `req_i[i]`, seen at a clock edge, sets pending bit i. A source input held high does not set the bit again after the bit has been cleared.
- R2: A source whose mask bit is 1 never contributes to `irq_o`. The mask register is at address 0 and has one bit per source, with bit i belonging to source i.
- R3: A source qualifies only if its level is numerically smaller than the threshold. The threshold sits at address 1, is 4 bits wide and resets to 8, which passes every level. A threshold of 0 blocks all sources.
- R4: A source whose own in-service bit is set does not qualify.
- R5: A source qualifies only if its level is numerically less than or equal to the level of every source that is in service. An equal level is allowed.
- R6: In an acknowledge cycle (`ack_i`=1 while `irq_o`=1), `vec_o` becomes 0x20 + i on the next clock edge. Source i is the qualifying source with the smallest level at that edge, and the lower index wins a tie.
- R7: The acknowledge clears the winner's pending bit and sets its in-service bit. The pending bits read at address 2. The in-service bits read at address 3.
- R8: A write to address 4 with data bit 7 = 0 clears the in-service bit of the source whose index is given in data bits 2..0.
- R9: A write to address 4 with data bit 7 = 1 clears the in-service bit of the in-service source with the smallest level, with the lower index winning a tie.
- R10: An acknowledge while `irq_o`=0 loads 0xFF into `vec_o` and changes no pending or in-service bit.
- R11: `irq_o` follows the registered state without a clock of delay and falls as soon as no source qualifies.
- R12: After reset, the mask register reads 0xFF, the threshold reads 8, and the pending and in-service registers read 0. The level of source i reads at address 8 + i and resets to 7. `vec_o` resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Source request lines, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Maskable interrupt request |
| ack_i | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| vec_o | output | 8 | Type number returned by the last acknowledge |

## Verification
A wrong pending or in-service bit shows on `irq_o` in the same cycle. The request line depends only on registered state, so a stray or missing bit raises or drops the line at once. It can also show as a wrong nesting decision once a handler is in service. A wrong winner or a wrong threshold comparison shows in `vec_o` one edge after the acknowledge. A bad end-of-interrupt target shows in the in-service readback right after the write. It then shows on `irq_o` as a source that stays blocked or one that is released too early.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [3:0] {
    A_MASK = 4'h0,
    A_THR  = 4'h1,
    A_PEND = 4'h2,
    A_ISR  = 4'h3,
    A_EOI  = 4'h4
  } nic_addr_e;

  localparam logic [3:0] A_PRIO_BASE = 4'h8;
  localparam int unsigned EOI_NS_BIT = 7;
endpackage

// File: rtl/nic_prio_min.sv
// Finds the valid entry with the smallest level; lower index wins ties.
module nic_prio_min #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]    vld_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW:0]     prio_o
);
  always_comb begin
    any_o  = |vld_i;
    idx_o  = '0;
    prio_o = {1'b1, {PW{1'b0}}};
    for (int i = 0; i < N; i++) begin
      if (vld_i[i] && ({1'b0, prio_i[i*PW +: PW]} < prio_o)) begin
        prio_o = {1'b0, prio_i[i*PW +: PW]};
        idx_o  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nic_src_slot.sv
// Per-source state: edge detect, level, pending and in-service bits.
module nic_src_slot #(
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          prio_we_i,
  input  logic [PW-1:0] prio_wdata_i,
  input  logic          ack_hit_i,
  input  logic          eoi_hit_i,
  output logic [PW-1:0] prio_o,
  output logic          pend_o,
  output logic          isr_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      prio_o <= '1;
      pend_o <= 1'b0;
      isr_o  <= 1'b0;
    end else begin
      req_q <= req_i;
      if (prio_we_i) prio_o <= prio_wdata_i;
      // a new edge in the ack cycle keeps the bit set
      pend_o <= (pend_o & ~ack_hit_i) | (req_i & ~req_q);
      isr_o  <= (isr_o & ~eoi_hit_i) | ack_hit_i;
    end
  end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl #(
  parameter int unsigned NUM_SRC   = 8,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [7:0]  TYPE_BASE = 8'h20,
  parameter logic [7:0]  SPUR_TYPE = 8'hFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  req_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  input  logic                ack_i,
  output logic [7:0]          vec_o
);
  import nic_pkg::*;

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned THR_W = PRIO_W + 1;

  logic [NUM_SRC-1:0]        mask_q;
  logic [THR_W-1:0]          thr_q;
  logic [NUM_SRC-1:0]        pend, isr, qual, ack_hit, eoi_hit, prio_we;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  logic              win_any, isr_any;
  logic [IDX_W-1:0]  win_idx, isr_idx, eoi_idx;
  logic [PRIO_W:0]   win_prio, isr_min;

  logic eoi_wr, eoi_ns;
  assign eoi_wr  = wr_en_i && (addr_i == ADDR_W'(A_EOI));
  assign eoi_ns  = wdata_i[EOI_NS_BIT];
  assign eoi_idx = eoi_ns ? isr_idx : wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      thr_q  <= {1'b1, {PRIO_W{1'b0}}};
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_W'(A_THR))  thr_q  <= wdata_i[THR_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_g;

    assign prio_we[g] = wr_en_i && (addr_i == ADDR_W'(A_PRIO_BASE) + ADDR_W'(g));
    assign ack_hit[g] = ack_i && irq_o && (win_idx == IDX_W'(g));
    assign eoi_hit[g] = eoi_wr && (eoi_idx == IDX_W'(g)) && (!eoi_ns || isr_any);

    nic_src_slot #(.PW(PRIO_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (req_i[g]),
      .prio_we_i    (prio_we[g]),
      .prio_wdata_i (wdata_i[PRIO_W-1:0]),
      .ack_hit_i    (ack_hit[g]),
      .eoi_hit_i    (eoi_hit[g]),
      .prio_o       (prio_g),
      .pend_o       (pend[g]),
      .isr_o        (isr[g])
    );

    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_g;
    assign qual[g] = pend[g] && !mask_q[g] && !isr[g]
                  && ({1'b0, prio_g} < thr_q)
                  && ({1'b0, prio_g} <= isr_min);
  end

  nic_prio_min #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_isr_min (
    .vld_i (isr), .prio_i (prio_flat),
    .any_o (isr_any), .idx_o (isr_idx), .prio_o (isr_min)
  );

  nic_prio_min #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_win (
    .vld_i (qual), .prio_i (prio_flat),
    .any_o (win_any), .idx_o (win_idx), .prio_o (win_prio)
  );

  assign irq_o = win_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_o <= SPUR_TYPE;
    else if (ack_i) vec_o <= irq_o ? (TYPE_BASE + 8'(win_idx)) : SPUR_TYPE;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i >= ADDR_W'(A_PRIO_BASE)) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (addr_i == ADDR_W'(A_PRIO_BASE) + ADDR_W'(i))
          rdata_o = DATA_W'(prio_flat[i*PRIO_W +: PRIO_W]);
    end else begin
      case (addr_i)
        ADDR_W'(A_MASK): rdata_o = DATA_W'(mask_q);
        ADDR_W'(A_THR):  rdata_o = DATA_W'(thr_q);
        ADDR_W'(A_PEND): rdata_o = DATA_W'(pend);
        ADDR_W'(A_ISR):  rdata_o = DATA_W'(isr);
        default:         rdata_o = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^win_prio;
endmodule

// File: rtl/nic_ctrl_chk.sv
module nic_ctrl_chk #(
  parameter int unsigned N         = 8,
  parameter int unsigned THR_W     = 4,
  parameter logic [7:0]  SPUR_TYPE = 8'hFF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             irq_o,
  input logic [7:0]       vec_o,
  input logic [N-1:0]     mask,
  input logic [THR_W-1:0] thr,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     isr
);
  assert_irq_needs_unmasked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend & ~mask));

  assert_irq_needs_idle_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend & ~isr));

  assert_thr_zero_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr == '0) |-> !irq_o);

  assert_spurious_type_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (vec_o == SPUR_TYPE));

  assert_ack_type_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (vec_o != SPUR_TYPE));

  assert_ack_sets_isr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (isr != '0));

  assert_isr_only_by_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((isr & ~$past(isr)) == '0));
endmodule

bind nic_ctrl nic_ctrl_chk #(.N(NUM_SRC), .THR_W(PRIO_W + 1), .SPUR_TYPE(SPUR_TYPE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack_i  (ack_i),
  .irq_o  (irq_o),
  .vec_o  (vec_o),
  .mask   (mask_q),
  .thr    (thr_q),
  .pend   (pend),
  .isr    (isr)
);

// File: tb/sim_nic_ctrl.sv
module sim_nic_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       ack_i = 1'b0;
  logic [7:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nic_ctrl u0 (
    .clk_i, .rst_ni, .req_i, .wr_en_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .ack_i, .vec_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp);
  endtask

  task automatic set_req(int i, logic v);
    @(negedge clk_i);
    req_i[i] = v;
    @(negedge clk_i);
  endtask

  // driver: push the expected type, then pulse acknowledge
  task automatic do_ack(string tag, logic [7:0] exp);
    @(negedge clk_i);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  // monitor: vec_o updates on the acknowledge edge, sample at the next negedge
  initial begin
    forever begin
      @(posedge clk_i);
      if (ack_i) begin
        @(negedge clk_i);
        if (exp_q.size() == 0) begin
          check("ack without expectation", 32'd1, 32'd0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, vec_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check("R12 irq after reset", irq_o, 0);
    check("R12 vec after reset", vec_o, 8'hFF);
    rd_chk("R12 mask reset", 4'h0, 8'hFF);
    rd_chk("R12 thr reset", 4'h1, 8'h08);
    rd_chk("R12 pend reset", 4'h2, 8'h00);
    rd_chk("R12 isr reset", 4'h3, 8'h00);
    rd_chk("R12 prio0 reset", 4'h8, 8'h07);

    wr(4'h8, 8'd5); wr(4'h9, 8'd2); wr(4'hA, 8'd2); wr(4'hB, 8'd6); wr(4'hD, 8'd1);
    rd_chk("R12 prio1 readback", 4'h9, 8'h02);
    wr(4'h0, 8'h00);

    // R1 / R11: edge on source 3 raises pending and irq
    set_req(3, 1'b1);
    rd_chk("R1 pend after edge", 4'h2, 8'h08);
    check("R11 irq with src3", irq_o, 1);

    // R6: source 0 (level 5) beats source 3 (level 6)
    set_req(0, 1'b1);
    do_ack("R6 level 5 over 6", 8'h20);
    rd_chk("R7 isr after ack", 4'h3, 8'h01);
    rd_chk("R7 pend after ack", 4'h2, 8'h08);
    check("R5 lower level blocked by isr", irq_o, 0);

    // R5 / R6: two level-2 sources at once, nesting over level 5
    @(negedge clk_i);
    req_i[1] = 1'b1; req_i[2] = 1'b1;
    @(negedge clk_i);
    check("R5 more urgent nests", irq_o, 1);
    do_ack("R6 tie lower index", 8'h21);
    check("R5 equal level allowed", irq_o, 1);
    do_ack("R6 second of tie", 8'h22);
    rd_chk("R7 isr three deep", 4'h3, 8'h07);
    check("R11 irq drops", irq_o, 0);

    // R9 non-specific EOI: level 2, lower index first
    wr(4'h4, 8'h80);
    rd_chk("R9 first non-specific", 4'h3, 8'h05);
    wr(4'h4, 8'h80);
    rd_chk("R9 second non-specific", 4'h3, 8'h01);
    check("R5 src3 still blocked", irq_o, 0);

    // R8 specific EOI
    wr(4'h4, 8'h00);
    rd_chk("R8 specific eoi src0", 4'h3, 8'h00);
    check("R11 irq after eoi", irq_o, 1);
    do_ack("R6 src3 served", 8'h23);

    // R4: new edge on src3 while in service
    set_req(3, 1'b0);
    set_req(3, 1'b1);
    rd_chk("R4 pend src3 again", 4'h2, 8'h08);
    check("R4 own isr blocks", irq_o, 0);
    wr(4'h4, 8'h03);
    check("R8 eoi releases src3", irq_o, 1);
    do_ack("R6 src3 again", 8'h23);
    wr(4'h4, 8'h03);
    @(negedge clk_i);
    rd_chk("R1 held level no re-set", 4'h2, 8'h00);
    check("R1 no irq from held level", irq_o, 0);

    // R2 mask
    wr(4'h0, 8'h10);
    set_req(4, 1'b1);
    rd_chk("R2 pend masked src", 4'h2, 8'h10);
    check("R2 masked no irq", irq_o, 0);
    wr(4'h0, 8'h00);
    check("R2 unmasked irq", irq_o, 1);

    // R3 threshold
    wr(4'h1, 8'h07);
    check("R3 level 7 not below 7", irq_o, 0);
    wr(4'h1, 8'h00);
    check("R3 zero blocks", irq_o, 0);
    wr(4'h1, 8'h08);
    check("R3 threshold 8 passes", irq_o, 1);

    // R10 spurious ack
    wr(4'h0, 8'hFF);
    check("R10 irq off", irq_o, 0);
    do_ack("R10 spurious type", 8'hFF);
    rd_chk("R10 pend unchanged", 4'h2, 8'h10);
    rd_chk("R10 isr unchanged", 4'h3, 8'h00);

    // R6: later, more urgent arrival wins at ack time
    wr(4'h0, 8'h00);
    check("R11 src4 request", irq_o, 1);
    set_req(5, 1'b1);
    do_ack("R6 late urgent wins", 8'h25);
    wr(4'h4, 8'h80);
    do_ack("R6 src4 after eoi", 8'h24);
    wr(4'h4, 8'h80);
    rd_chk("R9 all released", 4'h3, 8'h00);

    repeat (3) @(negedge clk_i);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule